// File: doc/BRIEF.md
# Stacked and Rotating Register Mapper

This block turns a logical general-register number into a physical slot of a 128-entry register file. Slots 0 to 31 are global and never move. Slots 32 to 127 form a circular pool of 96 registers that holds a stack of procedure frames. Each frame has a local part followed by an outgoing part. When a procedure calls another, the callee's frame begins at the caller's outgoing part, so arguments pass without any copying. A return command brings back the caller's frame from an internal save stack that is eight entries deep.

An allocate command sets three sizes for the current frame: the whole frame, the locals, and a rotating region at the bottom of the frame. A rotate command renames the registers of the rotating region for each iteration of a software-pipelined loop. The block does not spill frames to memory. When the physical pool or the save stack cannot hold a request, it refuses the request and raises a one-cycle overflow flag. A return with nothing saved raises an underflow flag. The lookup is purely combinational from the committed frame state. Commands take effect on the clock edge that samples them.

Top module: `regStackMapper`

## Requirements
- R1: A logical index below 32 maps to the same physical index, whatever the frame state.
- R2: For a logical index L of 32 or more, the offset is o = L - 32. The physical index is 32 + ((base + o') mod 96), where o' is the rotated offset. Out of reset, base is 0, all sizes are 0 and the rotation count is 0.
- R3: Allocate sets the frame size, the local size and the rotating size, and clears the rotation count. It is ignored, with the state unchanged, when the rotating size is not a multiple of 8, exceeds the frame size, or when the local size exceeds the frame size.
- R4: Rotate decrements the rotation count modulo the rotating size, wrapping from 0 to size-1. An offset o below the rotating size becomes (o + count) mod size, and other offsets are not rotated. Rotate has no effect when the rotating size is 0.
- R5: Call saves the whole current frame state. The new base is (base + locals) mod 96 and the new frame size is frame - locals. The new local size, rotating size and rotation count are all 0.
- R6: Return restores the base, frame size, local size, rotating size and rotation count that the matching call saved.
- R7: Return with no saved frame raises underflow for exactly the cycle after the command and leaves the state unchanged.
- R8: Overflow is raised for one cycle, and the command is refused, on two conditions. The first is a call when 8 frames are already saved. The second is a valid allocate whose frame size, added to the locals of all saved frames, exceeds 96.
- R9: When several commands are asserted together, only one acts. The order of precedence is return, then call, then allocate, then rotate.
- R10: Both flags are low in every cycle that does not follow a refused command. With no command accepted, the physical index depends only on the logical index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| callEn | input | 1 | Call command |
| retEn | input | 1 | Return command |
| allocEn | input | 1 | Allocate command |
| rotEn | input | 1 | Rotate command |
| allocFrame | input | 7 | Frame size for allocate |
| allocLocals | input | 7 | Local size for allocate |
| allocRot | input | 7 | Rotating size for allocate |
| logIdx | input | 7 | Logical register index |
| physIdx | output | 7 | Physical register index |
| ovfFlag | output | 1 | Overflow, one cycle after a refused call or allocate |
| unfFlag | output | 1 | Underflow, one cycle after a return on an empty stack |

## Verification
The physical index has zero cycles of latency from the logical index. A command changes the mapping at the edge that samples it. The flags are registered and are valid for the one cycle after that edge. The bench drives each stimulus on a falling edge and queues the expected result. The monitor compares it a quarter period after the next rising edge. A lookup is only issued after its preceding command has been withdrawn, so every mapping compare sees the settled state, and every flag compare falls in the single cycle when that flag is due.

// File: rtl/regMapPkg.sv
package regMapPkg;
  localparam int IDX_W     = 7;
  localparam int NUM_REGS  = 128;
  localparam int NUM_FIXED = 32;
  localparam int NUM_STACK = NUM_REGS - NUM_FIXED;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic doCall;
    logic doRet;
    logic doAlloc;
    logic doRot;
  } mapStrobes_t;

  typedef struct packed {
    idx_t base;
    idx_t frame;
    idx_t locals;
    idx_t rot;
    idx_t rrb;
  } frameState_t;
endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import regMapPkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W = $clog2(STACK_DEPTH + 1),
  localparam int DEPTH_W = IDX_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            callEn,
  input  logic            retEn,
  input  logic            allocEn,
  input  logic            rotEn,
  input  idx_t            allocFrame,
  input  idx_t            allocLocals,
  input  idx_t            allocRot,
  input  idx_t            curLocals,
  input  idx_t            topLocals,
  output mapStrobes_t     strobes,
  output logic [SP_W-1:0] sp,
  output logic            ovfFlag,
  output logic            unfFlag
);
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(STACK_DEPTH);
  localparam logic [DEPTH_W-1:0] POOL = DEPTH_W'(NUM_STACK);

  logic [DEPTH_W-1:0] depthUsed;
  logic [DEPTH_W-1:0] allocTotal;
  logic allocValid, allocFits, stackEmpty, stackFull;

  always_comb begin
    stackEmpty = (sp == '0);
    stackFull  = (sp == SP_FULL);
    allocValid = (allocRot <= allocFrame) && (allocLocals <= allocFrame) &&
                 (allocRot[2:0] == 3'b000);
    allocTotal = depthUsed + DEPTH_W'(allocFrame);
    allocFits  = (allocTotal <= POOL);

    strobes.doRet   = retEn && !stackEmpty;
    strobes.doCall  = !retEn && callEn && !stackFull;
    strobes.doAlloc = !retEn && !callEn && allocEn && allocValid && allocFits;
    strobes.doRot   = !retEn && !callEn && !allocEn && rotEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp        <= '0;
      depthUsed <= '0;
      ovfFlag   <= 1'b0;
      unfFlag   <= 1'b0;
    end else begin
      unfFlag <= retEn && stackEmpty;
      ovfFlag <= !retEn && ((callEn && stackFull) ||
                            (!callEn && allocEn && allocValid && !allocFits));
      if (strobes.doCall) begin
        sp        <= sp + 1'b1;
        depthUsed <= depthUsed + DEPTH_W'(curLocals);
      end else if (strobes.doRet) begin
        sp        <= sp - 1'b1;
        depthUsed <= depthUsed - DEPTH_W'(topLocals);
      end
    end
  end
endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import regMapPkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W = $clog2(STACK_DEPTH + 1),
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1,
  localparam int SUM_W = IDX_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  mapStrobes_t     strobes,
  input  logic [SP_W-1:0] sp,
  input  idx_t            allocFrame,
  input  idx_t            allocLocals,
  input  idx_t            allocRot,
  input  idx_t            logIdx,
  output idx_t            curLocals,
  output idx_t            topLocals,
  output idx_t            physIdx
);
  localparam logic [SUM_W-1:0] POOL = SUM_W'(NUM_STACK);
  localparam idx_t FIXED = IDX_W'(NUM_FIXED);

  frameState_t cur;
  frameState_t saved [STACK_DEPTH];

  logic [PTR_W-1:0] pushPtr, popPtr;
  logic [SUM_W-1:0] callBase;

  always_comb begin
    pushPtr  = PTR_W'(sp);
    popPtr   = PTR_W'(sp - 1'b1);
    callBase = SUM_W'(cur.base) + SUM_W'(cur.locals);
    if (callBase >= POOL) callBase = callBase - POOL;
  end

  assign curLocals = cur.locals;
  assign topLocals = (sp == '0) ? '0 : saved[popPtr].locals;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) saved[i] <= '0;
    end else if (strobes.doRet) begin
      cur <= saved[popPtr];
    end else if (strobes.doCall) begin
      saved[pushPtr] <= cur;
      cur.base   <= IDX_W'(callBase);
      cur.frame  <= cur.frame - cur.locals;
      cur.locals <= '0;
      cur.rot    <= '0;
      cur.rrb    <= '0;
    end else if (strobes.doAlloc) begin
      cur.frame  <= allocFrame;
      cur.locals <= allocLocals;
      cur.rot    <= allocRot;
      cur.rrb    <= '0;
    end else if (strobes.doRot && (cur.rot != '0)) begin
      cur.rrb <= (cur.rrb == '0) ? cur.rot - 1'b1 : cur.rrb - 1'b1;
    end
  end

  // Translation: rotate inside the rotating region, then wrap into the pool
  idx_t             offset;
  logic [SUM_W-1:0] rotSum;
  logic [SUM_W-1:0] poolSum;

  always_comb begin
    offset = logIdx - FIXED;
    rotSum = SUM_W'(offset);
    if (offset < cur.rot) begin
      rotSum = SUM_W'(offset) + SUM_W'(cur.rrb);
      if (rotSum >= SUM_W'(cur.rot)) rotSum = rotSum - SUM_W'(cur.rot);
    end
    poolSum = SUM_W'(cur.base) + rotSum;
    if (poolSum >= POOL) poolSum = poolSum - POOL;
    if (logIdx < FIXED) physIdx = logIdx;
    else                physIdx = FIXED + IDX_W'(poolSum);
  end
endmodule

// File: rtl/regStackMapper.sv
module regStackMapper
  import regMapPkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       callEn,
  input  logic       retEn,
  input  logic       allocEn,
  input  logic       rotEn,
  input  logic [6:0] allocFrame,
  input  logic [6:0] allocLocals,
  input  logic [6:0] allocRot,
  input  logic [6:0] logIdx,
  output logic [6:0] physIdx,
  output logic       ovfFlag,
  output logic       unfFlag
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  mapStrobes_t     strobes;
  logic [SP_W-1:0] sp;
  idx_t            curLocals, topLocals;

  mapCtrl #(.STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .callEn(callEn), .retEn(retEn), .allocEn(allocEn), .rotEn(rotEn),
    .allocFrame(allocFrame), .allocLocals(allocLocals), .allocRot(allocRot),
    .curLocals(curLocals), .topLocals(topLocals),
    .strobes(strobes), .sp(sp), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  mapDatapath #(.STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sp(sp),
    .allocFrame(allocFrame), .allocLocals(allocLocals), .allocRot(allocRot),
    .logIdx(logIdx), .curLocals(curLocals), .topLocals(topLocals),
    .physIdx(physIdx)
  );
endmodule

// File: rtl/mapChecker.sv
module mapChecker (
  input logic       clk,
  input logic       rstN,
  input logic       callEn,
  input logic       retEn,
  input logic       allocEn,
  input logic       rotEn,
  input logic [6:0] logIdx,
  input logic [6:0] physIdx,
  input logic       ovfFlag,
  input logic       unfFlag
);
  logic anyCmd;
  assign anyCmd = callEn || retEn || allocEn || rotEn;

  assert_fixed_identity_R1: assert property (@(posedge clk) disable iff (!rstN)
    (logIdx < 7'd32) |-> (physIdx == logIdx));

  assert_stacked_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (logIdx >= 7'd32) |-> (physIdx >= 7'd32));

  assert_unf_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> $past(retEn));

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> ($past(callEn || allocEn) && !$past(retEn)));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(anyCmd) |-> (!ovfFlag && !unfFlag));

  assert_map_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(anyCmd) && $stable(logIdx)) |-> $stable(physIdx));
endmodule

bind regStackMapper mapChecker u_chk (
  .clk(clk), .rstN(rstN), .callEn(callEn), .retEn(retEn),
  .allocEn(allocEn), .rotEn(rotEn), .logIdx(logIdx),
  .physIdx(physIdx), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
);

// File: tb/tb_regStackMapper.sv
module tb_regStackMapper;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic callEn = 0, retEn = 0, allocEn = 0, rotEn = 0;
  logic [6:0] allocFrame = '0, allocLocals = '0, allocRot = '0, logIdx = '0;
  logic [6:0] physIdx;
  logic ovfFlag, unfFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regStackMapper dut (
    .clk(clk), .rstN(rstN), .callEn(callEn), .retEn(retEn),
    .allocEn(allocEn), .rotEn(rotEn), .allocFrame(allocFrame),
    .allocLocals(allocLocals), .allocRot(allocRot), .logIdx(logIdx),
    .physIdx(physIdx), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  typedef struct {
    bit    isCmd;
    int    expPhys;
    bit    expOvf;
    bit    expUnf;
    string tag;
  } item_t;

  item_t sbQueue[$];

  // Monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (sbQueue.size() > 0) begin
        item_t it;
        it = sbQueue.pop_front();
        checks++;
        if (it.isCmd) begin
          if (ovfFlag !== it.expOvf || unfFlag !== it.expUnf) begin
            errors++;
            $display("FAIL %s flags ovf/unf actual %0b/%0b expected %0b/%0b",
                     it.tag, ovfFlag, unfFlag, it.expOvf, it.expUnf);
          end
        end else begin
          if (physIdx !== 7'(it.expPhys) || ovfFlag !== 1'b0 || unfFlag !== 1'b0) begin
            errors++;
            $display("FAIL %s phys actual %0d expected %0d (flags %0b/%0b)",
                     it.tag, physIdx, it.expPhys, ovfFlag, unfFlag);
          end
        end
      end
    end
  end

  task automatic look(input int idx, input int expPhys, input string tag);
    item_t it;
    @(negedge clk);
    logIdx = 7'(idx);
    it.isCmd = 0; it.expPhys = expPhys; it.expOvf = 0; it.expUnf = 0; it.tag = tag;
    sbQueue.push_back(it);
  endtask

  task automatic cmd(input bit c, input bit r, input bit a, input bit t,
                     input int fs, input int ls, input int rs,
                     input bit eOvf, input bit eUnf, input string tag);
    item_t it;
    @(negedge clk);
    callEn = c; retEn = r; allocEn = a; rotEn = t;
    allocFrame = 7'(fs); allocLocals = 7'(ls); allocRot = 7'(rs);
    it.isCmd = 1; it.expPhys = 0; it.expOvf = eOvf; it.expUnf = eUnf; it.tag = tag;
    sbQueue.push_back(it);
    @(negedge clk);
    callEn = 0; retEn = 0; allocEn = 0; rotEn = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired, actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    look(5, 5, "R1 reset fixed");
    look(40, 40, "R2 reset base 0");
    look(127, 127, "R2 reset top");

    // Allocate frame 16, locals 8, rotating 8
    cmd(0,0,1,0, 16,8,8, 0,0, "R3 alloc ok");
    look(32, 32, "R3 rrb cleared");
    look(39, 39, "R3 rot region unrotated");

    // Rotation
    cmd(0,0,0,1, 0,0,0, 0,0, "R4 rotate");
    look(32, 39, "R4 wrap rrb to 7");
    look(33, 32, "R4 rotated offset");
    look(40, 40, "R4 outside rot region");
    look(10, 10, "R1 fixed after rotate");
    cmd(0,0,0,1, 0,0,0, 0,0, "R4 rotate 2");
    look(32, 38, "R4 rrb 6");

    // Invalid allocates ignored
    cmd(0,0,1,0, 16,8,12, 0,0, "R3 rot not multiple of 8");
    look(32, 38, "R3 invalid alloc ignored");
    cmd(0,0,1,0, 8,8,16, 0,0, "R3 rot beyond frame");
    look(32, 38, "R3 oversize rot ignored");
    cmd(0,0,1,0, 8,9,0, 0,0, "R3 locals beyond frame");
    look(32, 38, "R3 oversize locals ignored");

    // Call with simultaneous rotate: call wins
    cmd(1,0,0,1, 0,0,0, 0,0, "R9 call+rotate");
    look(32, 40, "R5 callee base 8");
    look(35, 43, "R9 rotate dropped");
    cmd(0,0,0,1, 0,0,0, 0,0, "R4 rotate with rot 0");
    look(32, 40, "R4 no effect at rot 0");

    // Pool overflow on allocate
    cmd(0,0,1,0, 90,0,0, 1,0, "R8 alloc beyond pool");
    look(32, 40, "R8 refused alloc state kept");
    cmd(0,0,1,0, 88,80,0, 0,0, "R8 alloc exactly fills pool");

    // Return restores caller
    cmd(0,1,0,0, 0,0,0, 0,0, "R6 return");
    look(32, 38, "R6 restored base and rrb");
    look(40, 40, "R6 restored frame");
    cmd(0,1,1,0, 0,0,0, 0,1, "R7 return empty");
    look(32, 38, "R7 state unchanged");

    // Save stack overflow
    cmd(0,0,1,0, 16,2,0, 0,0, "R3 alloc for depth test");
    for (int i = 0; i < 8; i++) cmd(1,0,0,0, 0,0,0, 0,0, "R5 call nest");
    look(32, 34, "R5 nested base");
    cmd(1,0,0,0, 0,0,0, 1,0, "R8 call on full stack");
    look(32, 34, "R8 refused call state kept");
    for (int i = 0; i < 8; i++) cmd(0,1,0,0, 0,0,0, 0,0, "R6 unwind");
    look(32, 32, "R6 unwound to base 0");
    look(47, 47, "R6 unwound frame");

    // Modulo wrap of the pool
    cmd(0,0,1,0, 96,88,0, 0,0, "R3 full pool frame");
    cmd(1,0,0,0, 0,0,0, 0,0, "R5 call to top");
    look(39, 127, "R2 top of pool");
    look(40, 32, "R2 wrap past pool");
    cmd(0,0,1,0, 8,0,8, 0,0, "R3 alloc callee rot");
    cmd(0,0,0,1, 0,0,0, 0,0, "R4 rotate at top");
    look(32, 127, "R4 rotated into top slot");
    look(33, 120, "R4 rotated at top");
    cmd(1,1,1,1, 0,0,0, 0,0, "R9 return wins");
    look(32, 32, "R9 return applied");

    repeat (2) @(negedge clk);
    finish();
  end
endmodule